// File: doc/BRIEF.md
# UDP Fixed-Offset Command Receiver

This block sits behind an Ethernet receive MAC and turns specially addressed UDP/IPv4 packets into register writes. The MAC hands it one frame at a time as a stream of bytes. Each byte comes with a valid flag, and the first and last bytes are marked. The frame check sequence has already been stripped. The block never parses variable-length headers. Instead it counts bytes from the first byte of the frame and compares each header field at a fixed position. This is sound only because IP options and fragmentation are both rejected.

When every header compare passes, the UDP destination port becomes the base register address. The payload is cut into big-endian words, and each complete word is issued as a one-cycle write strobe with its address and data. The address rises by one for each word. A frame that fails any compare, or that ends inside the header, is dropped without a trace. A payload that ends partway through a word still has its complete words written. The trailing bytes are discarded, and a one-cycle error pulse is raised.

The block has no address resolution, no transmit path and no checksum checks. The peer host is expected to hold a static address-resolution entry for this node.

Top module: `udp_cmd_rx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `wr_en` and `err_partial` are low.
- R2: For an accepted frame, payload byte 42 + 4k through 45 + 4k form word k, with the lowest-offset byte in bits 31:24. Each word is written once, at address (destination port bits [ADDR_W-1:0]) + k modulo 2^ADDR_W. The port is big-endian at bytes 36 (high) and 37 (low).
- R3: Bytes 0..5 must equal `LOCAL_MAC`, most significant byte first, or all be 0xFF when `ACCEPT_BCAST` is 1. Any other destination causes the frame to be dropped, with no write.
- R4: Byte 12 must be 0x08, byte 13 must be 0x00 and byte 14 must be 0x45. Otherwise the frame is dropped.
- R5: Byte 23, the IP protocol, must be 17. Otherwise the frame is dropped.
- R6: Bytes 30..33 must equal `LOCAL_IP`, most significant byte first. Otherwise the frame is dropped.
- R7: Bits 5:0 of byte 20 and all of byte 21 must be zero, meaning no more-fragments flag and a zero fragment offset. Bit 6 of byte 20, the don't-fragment flag, is ignored.
- R8: A frame whose last byte has an offset below 42 produces no write and no error pulse.
- R9: When the last byte of an accepted frame leaves a word incomplete, `err_partial` pulses for exactly one cycle, the partial word is not written, and the earlier complete words are written.
- R10: The IP and UDP checksum bytes (24..25, 40..41), the source addresses and the length fields have no effect on acceptance or on the written values.
- R11: `wr_en` pulses for one cycle, in the cycle after the clock edge that samples the word's final byte. Cycles with `in_valid` low are ignored, whatever `in_sof`, `in_eof` or `in_data` carry.
- R12: An `in_sof` byte always restarts the offset count and the header checks, even if the previous frame never saw `in_eof`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Byte on `in_data` is valid this cycle |
| in_sof | input | 1 | Valid byte is the first of a frame |
| in_eof | input | 1 | Valid byte is the last of a frame |
| in_data | input | 8 | Received frame byte |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | ADDR_W | Register address of the write |
| wr_data | output | 8*WORD_BYTES | Big-endian payload word |
| err_partial | output | 1 | One-cycle pulse: accepted frame ended mid-word |

## Verification
The bench targets the single-byte boundaries of each header field. One case changes only the last byte of the destination MAC, which a design that stopped comparing early would accept. Another sets only the don't-fragment flag, which an over-strict fragment check would reject. A destination port with all low bits set checks that the word address wraps rather than carrying into bits above ADDR_W. Frames that end exactly at the payload start, or two bytes past a word boundary, separate a design that writes a zero-filled partial word, or pulses the error on header-only frames, from a correct one. Idle cycles carrying stray start and end flags, and a frame restarted without an end marker, expose a counter that advances on invalid cycles or that waits for an end-of-frame before resetting.

// File: rtl/udpc_pkg.sv
// Shared types and fixed frame offsets for the UDP command receiver.
// Assumes an untagged Ethernet II frame, a 20-byte IPv4 header and no options.
package udpc_pkg;

    localparam int IDX_W = 11;                 // byte offsets saturate at 2047
    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [7:0]       octet_t;

    localparam idx_t OFS_ETYPE_HI = idx_t'(12);
    localparam idx_t OFS_ETYPE_LO = idx_t'(13);
    localparam idx_t OFS_VER_IHL  = idx_t'(14);
    localparam idx_t OFS_FRAG_HI  = idx_t'(20);
    localparam idx_t OFS_FRAG_LO  = idx_t'(21);
    localparam idx_t OFS_PROTO    = idx_t'(23);
    localparam idx_t OFS_DST_IP   = idx_t'(30);
    localparam idx_t OFS_PORT_HI  = idx_t'(36);
    localparam idx_t OFS_PORT_LO  = idx_t'(37);
    localparam idx_t OFS_PAYLOAD  = idx_t'(42);

    localparam octet_t ETYPE_HI_VAL = 8'h08;
    localparam octet_t ETYPE_LO_VAL = 8'h00;
    localparam octet_t VER_IHL_VAL  = 8'h45;
    localparam octet_t PROTO_UDP    = 8'd17;
    localparam octet_t FRAG_HI_MASK = 8'h3F;   // more-fragments flag + offset high bits

endpackage

// File: rtl/udpc_byte_index.sv
// Byte offset tracker. Produces the offset of the byte present this cycle,
// counted from the start-of-frame byte, and a flag saying the byte belongs
// to a frame. Assumes in_sof marks offset 0; bytes before any in_sof are
// ignored. The offset saturates at its maximum.
module udpc_byte_index
    import udpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_sof,
    input  logic in_eof,
    output logic take,
    output idx_t idx
);

    idx_t next_q;
    logic active_q;

    // Byte is accepted when valid and either opens a frame or continues one.
    assign take = in_valid & (in_sof | active_q);
    assign idx  = in_sof ? '0 : next_q;

    // Advance the offset and track whether a frame is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            next_q   <= '0;
        end else if (take) begin
            active_q <= !in_eof;
            next_q   <= (idx == '1) ? idx : idx + idx_t'(1);
        end
    end

endmodule

// File: rtl/udpc_hdr_match.sv
// Header checker. Compares each header byte at its fixed offset against the
// configured or constant value and keeps running pass flags for the frame.
// Captures the UDP destination port. hdr_pass reflects all bytes accepted so
// far in the current frame; it is meaningful once offset 42 is reached.
module udpc_hdr_match
    import udpc_pkg::*;
#(
    parameter logic [47:0] LOCAL_MAC    = 48'h02_12_34_56_78_9A,
    parameter logic [31:0] LOCAL_IP     = 32'hC0A8_0A07,
    parameter bit          ACCEPT_BCAST = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        take,
    input  logic        sof,
    input  idx_t        idx,
    input  octet_t      data,
    output logic        hdr_pass,
    output logic [15:0] dport
);

    logic fld_hit, uni_hit, bc_hit;
    logic fld_q, uni_q, bc_q;
    logic mac_ok;

    // Per-byte compare against the expected value at this offset.
    always_comb begin
        fld_hit = 1'b1;
        uni_hit = 1'b1;
        bc_hit  = 1'b1;
        for (int b = 0; b < 6; b++) begin
            if (idx == idx_t'(b)) begin
                uni_hit = (data == LOCAL_MAC[8*(5-b) +: 8]);
                bc_hit  = (data == 8'hFF);
            end
        end
        for (int b = 0; b < 4; b++) begin
            if (idx == OFS_DST_IP + idx_t'(b))
                fld_hit = (data == LOCAL_IP[8*(3-b) +: 8]);
        end
        case (idx)
            OFS_ETYPE_HI: fld_hit = (data == ETYPE_HI_VAL);
            OFS_ETYPE_LO: fld_hit = (data == ETYPE_LO_VAL);
            OFS_VER_IHL:  fld_hit = (data == VER_IHL_VAL);
            OFS_FRAG_HI:  fld_hit = ((data & FRAG_HI_MASK) == 8'h00);
            OFS_FRAG_LO:  fld_hit = (data == 8'h00);
            OFS_PROTO:    fld_hit = (data == PROTO_UDP);
            default:      ;
        endcase
    end

    // Accumulate pass flags; a start-of-frame byte reopens them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld_q <= 1'b0;
            uni_q <= 1'b0;
            bc_q  <= 1'b0;
        end else if (take) begin
            fld_q <= (sof | fld_q) & fld_hit;
            uni_q <= (sof | uni_q) & uni_hit;
            bc_q  <= (sof | bc_q)  & bc_hit;
        end
    end

    // Capture the big-endian destination port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dport <= '0;
        end else if (take) begin
            if (idx == OFS_PORT_HI) dport[15:8] <= data;
            if (idx == OFS_PORT_LO) dport[7:0]  <= data;
        end
    end

    generate
        if (ACCEPT_BCAST) begin : g_bcast
            assign mac_ok = uni_q | bc_q;
        end else begin : g_unicast
            assign mac_ok = uni_q;
        end
    endgenerate

    assign hdr_pass = fld_q & mac_ok;

endmodule

// File: rtl/udpc_word_pack.sv
// Payload packer. Gathers payload bytes of an accepted frame into big-endian
// words and issues one registered write per complete word, addressed from
// the port base plus the word number. Drops a trailing partial word and
// pulses an error for it. Assumes ADDR_W <= 16.
module udpc_word_pack
    import udpc_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int WORD_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    take,
    input  logic                    sof,
    input  logic                    eof,
    input  idx_t                    idx,
    input  octet_t                  data,
    input  logic                    hdr_pass,
    input  logic [15:0]             port_base,
    output logic                    wr_en,
    output logic [ADDR_W-1:0]       wr_addr,
    output logic [8*WORD_BYTES-1:0] wr_data,
    output logic                    err
);

    localparam int LANE_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
    localparam int ACC_W  = 8 * (WORD_BYTES - 1);
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(WORD_BYTES - 1);

    logic [LANE_W-1:0] lane_q;
    logic [ACC_W-1:0]  acc_q;
    logic [ADDR_W-1:0] widx_q;
    logic              pay;
    logic              word_done;

    // Payload byte of a frame whose header passed.
    assign pay       = take & !sof & hdr_pass & (idx >= OFS_PAYLOAD);
    assign word_done = pay & (lane_q == LAST_LANE);

    // Assemble words, count lanes and word number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= '0;
            acc_q  <= '0;
            widx_q <= '0;
        end else if (take) begin
            if (sof) begin
                lane_q <= '0;
                widx_q <= '0;
            end else if (pay) begin
                if (word_done) begin
                    lane_q <= '0;
                    widx_q <= widx_q + ADDR_W'(1);
                end else begin
                    lane_q <= lane_q + LANE_W'(1);
                end
                acc_q <= {acc_q[ACC_W-9:0], data};
            end
            if (eof) lane_q <= '0;
        end
    end

    // Registered write strobe, address and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= word_done;
            if (word_done) begin
                wr_addr <= port_base[ADDR_W-1:0] + widx_q;
                wr_data <= {acc_q, data};
            end
        end
    end

    // Error pulse for a frame ending inside a word.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= pay & eof & !word_done;
    end

endmodule

// File: rtl/udp_cmd_rx.sv
// UDP fixed-offset command receiver top. Takes a MAC receive byte stream
// (FCS removed), checks a UDP/IPv4 packet by fixed offsets, and converts the
// payload into register writes based at the UDP destination port.
// Assumes no VLAN tag, no IP options and no fragmentation.
module udp_cmd_rx
    import udpc_pkg::*;
#(
    parameter int          ADDR_W       = 8,
    parameter int          WORD_BYTES   = 4,
    parameter logic [47:0] LOCAL_MAC    = 48'h02_12_34_56_78_9A,
    parameter logic [31:0] LOCAL_IP     = 32'hC0A8_0A07,
    parameter bit          ACCEPT_BCAST = 1'b1,
    localparam int         DATA_W       = 8 * WORD_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [7:0]        in_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              err_partial
);

    logic        take;
    idx_t        idx;
    logic        hdr_pass;
    logic [15:0] dport;

    udpc_byte_index u_index (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_eof   (in_eof),
        .take     (take),
        .idx      (idx)
    );

    udpc_hdr_match #(
        .LOCAL_MAC    (LOCAL_MAC),
        .LOCAL_IP     (LOCAL_IP),
        .ACCEPT_BCAST (ACCEPT_BCAST)
    ) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .sof      (in_sof),
        .idx      (idx),
        .data     (in_data),
        .hdr_pass (hdr_pass),
        .dport    (dport)
    );

    udpc_word_pack #(
        .ADDR_W     (ADDR_W),
        .WORD_BYTES (WORD_BYTES)
    ) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .sof       (in_sof),
        .eof       (in_eof),
        .idx       (idx),
        .data      (in_data),
        .hdr_pass  (hdr_pass),
        .port_base (dport),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .err       (err_partial)
    );

endmodule

// File: rtl/udpc_checker.sv
// Port-level properties of the UDP command receiver, bound to the top.
module udpc_checker (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_eof,
    input logic wr_en,
    input logic err_partial
);

    // R11: a write strobe lasts a single cycle
    assert_wr_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R11: a write follows an accepted byte in the previous cycle
    assert_wr_after_byte_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(in_valid));

    // R9: the partial-word error lasts a single cycle
    assert_err_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_partial |=> !err_partial);

    // R9: the error only follows an end-of-frame byte
    assert_err_after_eof_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_partial |-> $past(in_valid && in_eof));

    // R9: a dropped partial word is never also written
    assert_err_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_partial |-> !wr_en);

endmodule

bind udp_cmd_rx udpc_checker u_udpc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_eof      (in_eof),
    .wr_en       (wr_en),
    .err_partial (err_partial)
);

// File: tb/tb_udp_cmd_rx.sv
`timescale 1ns/1ps
module tb_udp_cmd_rx;

    localparam int          ADDR_W = 8;
    localparam logic [47:0] MAC    = 48'h02_12_34_56_78_9A;
    localparam logic [31:0] IP     = 32'hC0A8_0A07;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_sof, in_eof;
    logic [7:0]  in_data;
    logic        wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [31:0] wr_data;
    logic        err_partial;

    udp_cmd_rx #(
        .ADDR_W(ADDR_W), .WORD_BYTES(4), .LOCAL_MAC(MAC), .LOCAL_IP(IP), .ACCEPT_BCAST(1'b1)
    ) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_data(in_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .err_partial(err_partial)
    );

    always #2.5 clk = ~clk;   // 200 MHz

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    logic [7:0] frm [0:127];
    int         flen;
    int         drv_cyc [0:127];

    logic [ADDR_W-1:0] log_addr [0:63];
    logic [31:0]       log_data [0:63];
    int                log_cyc  [0:63];
    int                nw, nerr;

    always @(posedge clk) cyc <= cyc + 1;

    // Record outputs away from the active edge.
    always @(negedge clk) begin
        if (wr_en && nw < 64) begin
            log_addr[nw] = wr_addr;
            log_data[nw] = wr_data;
            log_cyc[nw]  = cyc;
            nw++;
        end
        if (err_partial) nerr++;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pay(input int i);
        return 8'((i * 7 + 16) & 255);
    endfunction

    function automatic logic [31:0] word(input int k);
        return {pay(4*k), pay(4*k+1), pay(4*k+2), pay(4*k+3)};
    endfunction

    task automatic clear_log();
        @(negedge clk);
        nw = 0;
        nerr = 0;
    endtask

    task automatic build(input logic [15:0] port, input int plen);
        for (int i = 0; i < 6; i++) frm[i] = MAC[8*(5-i) +: 8];
        for (int i = 6; i < 12; i++) frm[i] = 8'(i);
        frm[12] = 8'h08; frm[13] = 8'h00; frm[14] = 8'h45; frm[15] = 8'h00;
        frm[16] = 8'h00; frm[17] = 8'(28 + plen); frm[18] = 8'h12; frm[19] = 8'h34;
        frm[20] = 8'h00; frm[21] = 8'h00; frm[22] = 8'd64; frm[23] = 8'd17;
        frm[24] = 8'h00; frm[25] = 8'h00;
        frm[26] = 8'd192; frm[27] = 8'd168; frm[28] = 8'd10; frm[29] = 8'd1;
        for (int i = 0; i < 4; i++) frm[30+i] = IP[8*(3-i) +: 8];
        frm[34] = 8'h30; frm[35] = 8'h39;
        frm[36] = port[15:8]; frm[37] = port[7:0];
        frm[38] = 8'h00; frm[39] = 8'(8 + plen); frm[40] = 8'h00; frm[41] = 8'h00;
        for (int i = 0; i < plen; i++) frm[42+i] = pay(i);
        flen = 42 + plen;
    endtask

    task automatic send(input int len, input bit gap, input bit no_eof);
        for (int i = 0; i < len; i++) begin
            if (gap && (i % 3 == 1)) begin
                @(negedge clk);
                in_valid = 1'b0; in_sof = 1'b1; in_eof = 1'b1; in_data = 8'hEE;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = frm[i];
            in_sof   = (i == 0);
            in_eof   = (i == len - 1) && !no_eof;
            drv_cyc[i] = cyc;
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h00;
        repeat (4) @(negedge clk);
    endtask

    task automatic expect_writes(input string req, input int nexp,
                                 input logic [15:0] port, input int errs);
        check(nw == nexp, req, "write count", nw, nexp);
        check(nerr == errs, req, "error pulses", nerr, errs);
        for (int k = 0; k < nexp && k < nw; k++) begin
            check(log_addr[k] == ADDR_W'(port + 16'(k)), req, "address", log_addr[k],
                  ADDR_W'(port + 16'(k)));
            check(log_data[k] == word(k), req, "data", log_data[k], word(k));
        end
    endtask

    task automatic t_reset_R1();
        rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h00;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(wr_en == 1'b0, "R1", "wr_en in reset", wr_en, 0);
        check(err_partial == 1'b0, "R1", "err in reset", err_partial, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(wr_en == 1'b0 && err_partial == 1'b0, "R1", "outputs after reset",
              {wr_en, err_partial}, 0);
    endtask

    task automatic t_basic_R2();
        clear_log(); build(16'h1234, 8); send(flen, 0, 0);
        expect_writes("R2", 2, 16'h1234, 0);
        clear_log(); build(16'hABFF, 12); send(flen, 0, 0);
        expect_writes("R2 wrap", 3, 16'hABFF, 0);
    endtask

    task automatic t_mac_R3();
        clear_log(); build(16'h0010, 4); frm[5] = frm[5] ^ 8'h01; send(flen, 0, 0);
        expect_writes("R3 last MAC byte", 0, 16'h0010, 0);
        clear_log(); build(16'h0010, 4); frm[0] = 8'h03; send(flen, 0, 0);
        expect_writes("R3 first MAC byte", 0, 16'h0010, 0);
        clear_log(); build(16'h0020, 8);
        for (int i = 0; i < 6; i++) frm[i] = 8'hFF;
        send(flen, 0, 0);
        expect_writes("R3 broadcast", 2, 16'h0020, 0);
    endtask

    task automatic t_type_R4();
        clear_log(); build(16'h0030, 4); frm[12] = 8'h86; frm[13] = 8'hDD; send(flen, 0, 0);
        expect_writes("R4 ethertype", 0, 16'h0030, 0);
        clear_log(); build(16'h0030, 4); frm[14] = 8'h46; send(flen, 0, 0);
        expect_writes("R4 options", 0, 16'h0030, 0);
    endtask

    task automatic t_proto_R5();
        clear_log(); build(16'h0040, 4); frm[23] = 8'd6; send(flen, 0, 0);
        expect_writes("R5", 0, 16'h0040, 0);
    endtask

    task automatic t_ip_R6();
        clear_log(); build(16'h0050, 4); frm[33] = frm[33] + 8'd1; send(flen, 0, 0);
        expect_writes("R6 last IP byte", 0, 16'h0050, 0);
        clear_log(); build(16'h0050, 4); frm[30] = 8'd10; send(flen, 0, 0);
        expect_writes("R6 first IP byte", 0, 16'h0050, 0);
    endtask

    task automatic t_frag_R7();
        clear_log(); build(16'h0060, 4); frm[20] = 8'h20; send(flen, 0, 0);
        expect_writes("R7 more-fragments", 0, 16'h0060, 0);
        clear_log(); build(16'h0060, 4); frm[21] = 8'h01; send(flen, 0, 0);
        expect_writes("R7 offset", 0, 16'h0060, 0);
        clear_log(); build(16'h0060, 4); frm[20] = 8'h40; send(flen, 0, 0);
        expect_writes("R7 dont-fragment", 1, 16'h0060, 0);
    endtask

    task automatic t_short_R8();
        clear_log(); build(16'h0070, 0); send(30, 0, 0);
        expect_writes("R8 30 bytes", 0, 16'h0070, 0);
        clear_log(); build(16'h0070, 0); send(42, 0, 0);
        expect_writes("R8 42 bytes", 0, 16'h0070, 0);
    endtask

    task automatic t_partial_R9();
        clear_log(); build(16'h0080, 6); send(flen, 0, 0);
        expect_writes("R9", 1, 16'h0080, 1);
        clear_log(); build(16'h0080, 3); send(flen, 0, 0);
        expect_writes("R9 under one word", 0, 16'h0080, 1);
    endtask

    task automatic t_cksum_R10();
        clear_log(); build(16'h0090, 8);
        frm[24] = 8'hDE; frm[25] = 8'hAD; frm[40] = 8'hBE; frm[41] = 8'hEF;
        frm[26] = 8'h0A; frm[16] = 8'h55; frm[39] = 8'h01; frm[8] = 8'hC3;
        send(flen, 0, 0);
        expect_writes("R10", 2, 16'h0090, 0);
    endtask

    task automatic t_gaps_R11();
        clear_log(); build(16'h00A0, 8); send(flen, 1, 0);
        expect_writes("R11 gaps", 2, 16'h00A0, 0);
        for (int k = 0; k < 2 && k < nw; k++)
            check(log_cyc[k] == drv_cyc[45 + 4*k] + 1, "R11", "write cycle",
                  log_cyc[k], drv_cyc[45 + 4*k] + 1);
    endtask

    task automatic t_restart_R12();
        clear_log(); build(16'h00B0, 8); frm[23] = 8'd6; send(20, 0, 1);
        build(16'h00C0, 8); send(flen, 0, 0);
        expect_writes("R12", 2, 16'h00C0, 0);
    endtask

    initial begin
        t_reset_R1();
        t_basic_R2();
        t_mac_R3();
        t_type_R4();
        t_proto_R5();
        t_ip_R6();
        t_frag_R7();
        t_short_R8();
        t_partial_R9();
        t_cksum_R10();
        t_gaps_R11();
        t_restart_R12();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule